// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss by walking a sparse two-level page table held in physical memory. A 32-bit virtual address is split into a super-table index (bits 31:22), a second-level index (bits 21:12) and a 12-bit offset within a 4 KB page. The walker reads one 32-bit word from the super table, and reads the second-level table only if the super entry is marked valid. It then returns either a translation that the TLB can load or a fault that names the failing level.

Requests arrive on a valid/ready channel and are accepted only when the walker is idle. Results leave on a valid/ready channel and are held until the consumer takes them, so the consumer can apply back-pressure for as long as it needs. Table words are read through a request/response port. A read request stays up, unchanged, until the memory accepts it. The response may then arrive after any number of cycles. The table root comes from a base-register input, which is sampled only when a request is accepted.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `res_valid` are 0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while no walk is in progress and no result is pending. A request offered at any other time has no effect on the walk in flight.
- R3: The first read goes to `root_base + 4*vaddr[31:22]`. `root_base` is captured when the request is accepted, and later changes on that input do not alter the walk.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the walker keeps `mem_req_valid` high and `mem_req_addr` unchanged in the next cycle.
- R5: A table entry has its valid flag at bit 0, access rights at bits 3:1 and a physical page number at bits 31:12. The second read goes to `{ppn_of_super_entry, 12'h000} + 4*vaddr[21:12]`.
- R6: If the super entry's valid bit is 0, the walk ends with `res_fault`=1 and `res_fault_level`=0, and no second read is issued.
- R7: If the second-level entry's valid bit is 0, the walk ends with `res_fault`=1 and `res_fault_level`=1.
- R8: On success, `res_fault`=0, `res_ppn` and `res_rights` are taken from the second-level entry, and `res_paddr` = `{res_ppn, vaddr[11:0]}`.
- R9: `res_valid` and all result fields stay unchanged until `res_ready` is high. `res_vaddr` carries the virtual address that was translated, including on a fault.
- R10: Memory responses are accepted after any number of wait cycles, from zero upwards. `mem_rsp_valid` outside a waiting phase is not expected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base address of the super table |
| mem_req_valid | output | 1 | Table word read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Walk ended on an invalid entry |
| res_fault_level | output | 1 | 0 = super level, 1 = second level |
| res_vaddr | output | 32 | Virtual address of this walk |
| res_paddr | output | 32 | Translated physical address |
| res_ppn | output | 20 | Physical page number for the TLB |
| res_rights | output | 3 | Access rights for the TLB |

## Verification
A corrupted walk state shows up at the ports within one cycle. A missing or extra read shows as a mismatch on `mem_req_valid`. A walker stuck busy or idle shows as a wrong `req_ready`, and the same fault can also release a result early. A wrongly latched index, base or table page number first appears as a wrong `mem_req_addr` in the cycle the read is issued. A wrongly captured entry appears in the result fields on the first cycle `res_valid` rises. The bench changes its memory latency and both ready signals each cycle, and it drives a garbage base address whenever no request is offered. This exposes any dependence on a stable base or on timing.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD1   = 3'd1,
    S_WT1   = 3'd2,
    S_RD2   = 3'd3,
    S_WT2   = 3'd4,
    S_DONE  = 3'd5,
    S_FAULT = 3'd6
  } walk_state_e;

  localparam int ENTRY_SHIFT = 2;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W    = 32,
  parameter int PPN_W    = 20,
  parameter int RIGHTS_W = 3
) (
  input  logic [PTE_W-1:0]    word,
  output logic                ok,
  output logic [RIGHTS_W-1:0] rights,
  output logic [PPN_W-1:0]    ppn
);
  always_comb begin
    ok     = word[0];
    rights = word[RIGHTS_W:1];
    ppn    = word[PTE_W-1 -: PPN_W];
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  parameter int VA_W  = 2*IDX_W + OFF_W,
  parameter int PPN_W = PA_W - OFF_W
) (
  input  logic             second,
  input  logic [PA_W-1:0]  root_base,
  input  logic [PPN_W-1:0] tbl_ppn,
  input  logic [VA_W-1:0]  vaddr,
  output logic [PA_W-1:0]  addr
);
  import ptw_pkg::*;
  localparam int HI_LSB = OFF_W + IDX_W;

  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  tbl_base;
  logic [PA_W-1:0]  idx_off;

  always_comb begin
    idx      = second ? vaddr[OFF_W +: IDX_W] : vaddr[HI_LSB +: IDX_W];
    tbl_base = second ? {tbl_ppn, {OFF_W{1'b0}}} : root_base;
    idx_off  = PA_W'(idx) << ENTRY_SHIFT;
    addr     = tbl_base + idx_off;
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_fire,
  input  logic                 mem_req_ready,
  input  logic                 mem_rsp_valid,
  input  logic                 entry_ok,
  input  logic                 res_ready,
  output ptw_pkg::walk_state_e state
);
  import ptw_pkg::*;
  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (req_fire) nxt = S_RD1;
      S_RD1:   if (mem_req_ready) nxt = S_WT1;
      S_WT1:   if (mem_rsp_valid) nxt = entry_ok ? S_RD2 : S_FAULT;
      S_RD2:   if (mem_req_ready) nxt = S_WT2;
      S_WT2:   if (mem_rsp_valid) nxt = entry_ok ? S_DONE : S_FAULT;
      S_DONE,
      S_FAULT: if (res_ready) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 12,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int RIGHTS_W = 3,
  parameter int VA_W     = 2*IDX_W + OFF_W,
  parameter int PPN_W    = PA_W - OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [PA_W-1:0]     root_base,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                res_fault,
  output logic                res_fault_level,
  output logic [VA_W-1:0]     res_vaddr,
  output logic [PA_W-1:0]     res_paddr,
  output logic [PPN_W-1:0]    res_ppn,
  output logic [RIGHTS_W-1:0] res_rights
);
  import ptw_pkg::*;

  walk_state_e        state;
  logic               req_fire;
  logic               ent_ok;
  logic [RIGHTS_W-1:0] ent_rights;
  logic [PPN_W-1:0]   ent_ppn;
  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    base_q;
  logic [PPN_W-1:0]   tbl_ppn_q;
  logic [PPN_W-1:0]   leaf_ppn_q;
  logic [RIGHTS_W-1:0] leaf_rights_q;
  logic               flt_lvl_q;

  assign req_ready = (state == S_IDLE);
  assign req_fire  = req_valid && req_ready;

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_fire),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .entry_ok      (ent_ok),
    .res_ready     (res_ready),
    .state         (state)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)) u_dec (
    .word   (mem_rsp_data),
    .ok     (ent_ok),
    .rights (ent_rights),
    .ppn    (ent_ppn)
  );

  ptw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .VA_W(VA_W), .PPN_W(PPN_W)) u_addr (
    .second    (state == S_RD2),
    .root_base (base_q),
    .tbl_ppn   (tbl_ppn_q),
    .vaddr     (va_q),
    .addr      (mem_req_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q          <= '0;
      base_q        <= '0;
      tbl_ppn_q     <= '0;
      leaf_ppn_q    <= '0;
      leaf_rights_q <= '0;
      flt_lvl_q     <= 1'b0;
    end else begin
      if (req_fire) begin
        va_q   <= req_vaddr;
        base_q <= root_base;
      end
      if (state == S_WT1 && mem_rsp_valid) begin
        tbl_ppn_q <= ent_ppn;
        flt_lvl_q <= 1'b0;
      end
      if (state == S_WT2 && mem_rsp_valid) begin
        leaf_ppn_q    <= ent_ppn;
        leaf_rights_q <= ent_rights;
        flt_lvl_q     <= 1'b1;
      end
    end
  end

  always_comb begin
    mem_req_valid   = (state == S_RD1) || (state == S_RD2);
    res_valid       = (state == S_DONE) || (state == S_FAULT);
    res_fault       = (state == S_FAULT);
    res_fault_level = flt_lvl_q;
    res_vaddr       = va_q;
    res_ppn         = leaf_ppn_q;
    res_rights      = leaf_rights_q;
    res_paddr       = {leaf_ppn_q, va_q[OFF_W-1:0]};
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_fault,
  input logic        res_fault_level,
  input logic [31:0] res_vaddr,
  input logic [31:0] res_paddr
);
  assert_idle_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid));

  assert_accept_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fault)
      && $stable(res_fault_level) && $stable(res_vaddr) && $stable(res_paddr)));

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (res_paddr[11:0] == res_vaddr[11:0]));

  assert_one_side_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, res_valid, req_ready}));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .res_valid       (res_valid),
  .res_ready       (res_ready),
  .res_fault       (res_fault),
  .res_fault_level (res_fault_level),
  .res_vaddr       (res_vaddr),
  .res_paddr       (res_paddr)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic        res_fault_level;
  logic [31:0] res_vaddr;
  logic [31:0] res_paddr;
  logic [19:0] res_ppn;
  logic [2:0]  res_rights;

  always #2.5 clk = ~clk;

  ptw_walker dut (.*);

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [int unsigned];
  logic [31:0] q_va [$];
  logic [31:0] q_base [$];

  // behavioural model
  int          phase = 0;  // 0 idle,1 rd super,2 wait,3 rd second,4 wait,5 ok,6 fault
  logic [31:0] m_va, m_base, m_e1, m_e2;
  int          m_lvl;
  int          results = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit pend = 0;
    int cnt = 0;
    logic [31:0] pdata = '0;
    bit f_req, f_mem, f_rsp, f_res;
    int cyc = 0;
    int idle_run = 0;

    // table contents: entry = {ppn[31:12], 8'h0, rights[3:1], valid[0]}
    mem[32'h0001_000C] = 32'h0020_0001;
    mem[32'h0020_0014] = 32'h000A_B00B;
    mem[32'h0001_0FFC] = 32'h0030_0007;
    mem[32'h0030_0FFC] = 32'hFFFF_F00F;
    mem[32'h0001_0000] = 32'h0040_0003;
    mem[32'h0040_0000] = 32'h1234_5003;
    mem[32'h0002_000C] = 32'h0050_0001;
    mem[32'h0050_0014] = 32'h0777_7001;
    q_va.push_back(32'h00C0_5ABC); q_base.push_back(32'h0001_0000); // success
    q_va.push_back(32'hFFFF_FFFF); q_base.push_back(32'h0001_0000); // top indices
    q_va.push_back(32'h0400_0123); q_base.push_back(32'h0001_0000); // super invalid
    q_va.push_back(32'h00C0_6777); q_base.push_back(32'h0001_0000); // second invalid
    q_va.push_back(32'h0000_0000); q_base.push_back(32'h0001_0000); // zero indices
    q_va.push_back(32'h00C0_5ABC); q_base.push_back(32'h0002_0000); // other root

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 res_valid", res_valid, 0);

    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", phase, 0);
        break;
      end
      // compare against model
      chk("R2 req_ready", req_ready, phase == 0);
      chk("R4 R6 mem_req_valid", mem_req_valid, phase == 1 || phase == 3);
      if (phase == 1)
        chk("R3 super address", mem_req_addr, m_base + {20'h0, m_va[31:22], 2'b00});
      if (phase == 3)
        chk("R5 second address", mem_req_addr, {m_e1[31:12], 12'h0} + {20'h0, m_va[21:12], 2'b00});
      chk("R9 res_valid", res_valid, phase == 5 || phase == 6);
      if (phase == 5 || phase == 6) begin
        chk("R9 res_vaddr", res_vaddr, m_va);
        chk("R6 R7 res_fault", res_fault, phase == 6);
        if (phase == 6) chk("R6 R7 fault level", res_fault_level, m_lvl);
        if (phase == 5) begin
          chk("R8 res_paddr", res_paddr, {m_e2[31:12], m_va[11:0]});
          chk("R8 res_ppn", res_ppn, m_e2[31:12]);
          chk("R8 res_rights", res_rights, m_e2[3:1]);
        end
      end

      // drive responses (R10: latency 0..3)
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hBAD0_0BAD;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0;
        end else cnt--;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = lfsr[0] | lfsr[3];
      res_ready     = lfsr[1];
      req_valid     = (q_va.size() != 0);
      req_vaddr     = req_valid ? q_va[0] : 32'h0;
      root_base     = req_valid ? q_base[0] : 32'hDEAD_0000;
      f_req = req_valid && req_ready;
      f_mem = mem_req_valid && mem_req_ready;
      f_rsp = mem_rsp_valid;
      f_res = res_valid && res_ready;
      if (f_mem) begin
        pend = 1; cnt = int'(lfsr[5:4]); pdata = rd(mem_req_addr);
      end

      @(posedge clk);
      case (phase)
        0: if (f_req) begin
             m_va = q_va.pop_front(); m_base = q_base.pop_front(); phase = 1;
           end
        1: if (f_mem) phase = 2;
        2: if (f_rsp) begin
             m_e1 = rd(m_base + {20'h0, m_va[31:22], 2'b00});
             if (m_e1[0]) phase = 3; else begin phase = 6; m_lvl = 0; end
           end
        3: if (f_mem) phase = 4;
        4: if (f_rsp) begin
             m_e2 = rd({m_e1[31:12], 12'h0} + {20'h0, m_va[21:12], 2'b00});
             if (m_e2[0]) phase = 5; else begin phase = 6; m_lvl = 1; end
           end
        default: if (f_res) begin phase = 0; results++; end
      endcase
      if (phase == 0 && q_va.size() == 0) idle_run++; else idle_run = 0;
      if (idle_run > 4) break;
    end

    chk("R8 walks completed", results, 6);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule